// File: doc/BRIEF.md
# Periodic and One-Shot Countdown Timer

A programmable down-counter. Its count falls by one on every tick of an internal tick generator. The tick period is a whole number of clock cycles plus a 32-bit binary fraction. The leftover fraction is carried forward from tick to tick, so over time it adds whole extra cycles and the average tick length matches the programmed period. Software drives the block through a one-command-per-cycle interface. That interface sets the period (as an integer or with a fraction), sets the limit (with or without an immediate load), writes the count, starts the timer in periodic or one-shot mode, and stops it. The live count and the mode can be read at any time.

When the count runs out, the block emits a one-cycle interrupt pulse. In one-shot mode the timer then falls back to off. In periodic mode it refills the count from the limit and keeps going. Guards stop the timer from running with a zero period or a zero limit. A zero count found at a restart point fires the interrupt and pulls the limit in.

The reset input asserts asynchronously. Its release passes through a two-stage synchronizer, so the block leaves reset on the second rising clock edge after `rst_n` rises.

Top module: `cdt_timer`

## Requirements
- R1: While reset is held, `mode_o` is 0, `count_o` is 0 and `irq_o` is 0.
- R2: `mode_o` reads 0 when off, 1 when periodic and 2 when one-shot. The value 3 never appears. `cmd_op_i` codes are: 0 integer period (fraction cleared), 1 period with fraction from `cmd_frac_i`, 2 limit only, 3 limit with count load, 4 count write, 5 start periodic, 6 start one-shot, 7 stop.
- R3: With integer period P, a running count first drops P clock edges after the edge that started or restarted the interval, then drops once every P edges.
- R4: A 32-bit accumulator adds the fraction at each tick, and its carry-out lengthens the next tick by one cycle. The accumulator clears at every start and restart. With P=2 and fraction 0x80000000, ticks fall at edges 2, 4, 7, 9, 12, 14, 17 after the start.
- R5: In one-shot mode, the tick that takes the count from 1 ends the run. After that edge `irq_o` is high for exactly that cycle, the count is 0 and the mode is 0.
- R6: In periodic mode, the tick that takes the count from 1 pulses `irq_o` and loads the limit. If the limit is 0 at that point, the timer turns off with count 0.
- R7: At a start, or at a count write while running, a zero count pulses `irq_o` and loads the limit. If the count is still zero after that, the timer turns off.
- R8: A start while running is ignored. A start with an integer period of zero is rejected: the mode stays 0 and no interrupt fires.
- R9: A limit-only write leaves the count untouched. A limit write with load copies the value into the count, and while running it restarts the interval.
- R10: A count write while stopped only stores the value. While running it restarts the current interval from the written value.
- R11: Stop sets the mode to 0 and holds the count. A later start begins a full period, discarding the partial tick.
- R12: A period write while running restarts the interval. A zero integer period turns the timer off. The integer form clears any earlier fraction.
- R13: Whenever the mode is nonzero, the count is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously |
| cmd_valid_i | input | 1 | A command is present this cycle |
| cmd_op_i | input | 3 | Command code (see R2) |
| cmd_data_i | input | CNT_W | Limit, count, or integer period in the low PER_W bits |
| cmd_frac_i | input | FRAC_W | Fractional period for code 1 |
| count_o | output | CNT_W | Live remaining count |
| mode_o | output | 2 | Current mode |
| irq_o | output | 1 | One-cycle expiry pulse |

## Verification
The bench goes after the places where a countdown timer usually slips.

- **Tick phase after restart.** A design that did not clear the phase counter on a restart, or that did not discard the partial tick at stop, would decrement early.
- **Fractional carry.** A design that dropped the carry, or that kept the accumulator across restarts, would put the ticks at the wrong edges. The bench checks them against the 2, 4, 7, 9 pattern.
- **Zero-value guards.** Missing guards would show up as a run that starts with period zero, a periodic run that spins on a zero limit, or a zero-count start that neither fires nor loads the limit.
- **Command priority.** A restart or stop must win over a tick in the same cycle. Getting this wrong would leave the count one step off after a restart or stop.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  typedef enum logic [1:0] {
    MODE_OFF      = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_ONESHOT  = 2'd2
  } cdt_mode_e;

  typedef enum logic [2:0] {
    OP_PER_INT   = 3'd0,
    OP_PER_FRAC  = 3'd1,
    OP_LIM       = 3'd2,
    OP_LIM_LOAD  = 3'd3,
    OP_CNT       = 3'd4,
    OP_RUN_PER   = 3'd5,
    OP_RUN_ONE   = 3'd6,
    OP_HALT      = 3'd7
  } cdt_op_e;

endpackage

// File: rtl/cdt_cfg.sv
// Configuration holding registers: limit, integer period and fraction.
module cdt_cfg #(
  parameter int CNT_W  = 32,
  parameter int PER_W  = 16,
  parameter int FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_per_int_i,
  input  logic              wr_per_frac_i,
  input  logic              wr_lim_i,
  input  logic [CNT_W-1:0]  data_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [CNT_W-1:0]  lim_nx_o,
  output logic [PER_W-1:0]  pint_q_o,
  output logic [PER_W-1:0]  pint_nx_o,
  output logic [FRAC_W-1:0] frac_q_o
);

  logic [CNT_W-1:0]  lim_q, lim_d;
  logic [PER_W-1:0]  pint_q, pint_d;
  logic [FRAC_W-1:0] frac_q, frac_d;
  logic              lim_en, per_en;

  always_comb begin
    lim_en = wr_lim_i;
    per_en = wr_per_int_i | wr_per_frac_i;
    lim_d  = lim_en ? data_i : lim_q;
    pint_d = per_en ? data_i[PER_W-1:0] : pint_q;
    frac_d = frac_q;
    if (wr_per_int_i)  frac_d = '0;
    if (wr_per_frac_i) frac_d = frac_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q  <= '0;
      pint_q <= '0;
      frac_q <= '0;
    end else begin
      if (lim_en) lim_q <= lim_d;
      if (per_en) begin
        pint_q <= pint_d;
        frac_q <= frac_d;
      end
    end
  end

  assign lim_nx_o  = lim_d;
  assign pint_q_o  = pint_q;
  assign pint_nx_o = pint_d;
  assign frac_q_o  = frac_q;

endmodule

// File: rtl/cdt_tick_gen.sv
// Tick generator: integer cycle counter plus fractional carry accumulator.
module cdt_tick_gen #(
  parameter int PER_W  = 16,
  parameter int FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              restart_i,
  input  logic [PER_W-1:0]  pint_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              tick_o
);

  localparam int EW = PER_W + 1;

  logic [PER_W-1:0]  cyc_q, cyc_d;
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic              extra_q, extra_d;
  logic [FRAC_W:0]   acc_sum;
  logic [EW-1:0]     cyc_nx, span;
  logic              at_end, clr, en;

  always_comb begin
    acc_sum = {1'b0, acc_q} + {1'b0, frac_i};
    cyc_nx  = {1'b0, cyc_q} + EW'(1);
    span    = {1'b0, pint_i} + EW'(extra_q);
    at_end  = run_i && (cyc_nx == span);
    clr     = !run_i || restart_i;
    en      = clr || run_i;
    cyc_d   = cyc_nx[PER_W-1:0];
    acc_d   = acc_q;
    extra_d = extra_q;
    if (clr) begin
      cyc_d   = '0;
      acc_d   = '0;
      extra_d = 1'b0;
    end else if (at_end) begin
      cyc_d   = '0;
      acc_d   = acc_sum[FRAC_W-1:0];
      extra_d = acc_sum[FRAC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q   <= '0;
      acc_q   <= '0;
      extra_q <= 1'b0;
    end else if (en) begin
      cyc_q   <= cyc_d;
      acc_q   <= acc_d;
      extra_q <= extra_d;
    end
  end

  assign tick_o = at_end && !restart_i;

endmodule

// File: rtl/cdt_ctrl.sv
// Mode state machine, count register and interrupt pulse.
module cdt_ctrl
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_per_i,
  input  logic             wr_lim_load_i,
  input  logic             wr_cnt_i,
  input  logic             run_per_i,
  input  logic             run_one_i,
  input  logic             halt_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic [CNT_W-1:0] lim_nx_i,
  input  logic [PER_W-1:0] pint_q_i,
  input  logic [PER_W-1:0] pint_nx_i,
  input  logic             tick_i,
  output cdt_mode_e        mode_o,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o,
  output logic             run_o,
  output logic             restart_o
);

  cdt_mode_e        mode_q, mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_q, irq_d;
  logic             running, start_ok, restart_cmd, cnt_en;
  logic [CNT_W+1:0] rl;

  // Reload evaluation: {dead, fire, count}
  function automatic logic [CNT_W+1:0] reload_f(input logic [CNT_W-1:0] c,
                                                input logic [CNT_W-1:0] lim);
    logic             fire;
    logic [CNT_W-1:0] nc;
    fire = (c == '0);
    nc   = fire ? lim : c;
    return {(nc == '0), fire, nc};
  endfunction

  always_comb begin
    running     = (mode_q != MODE_OFF);
    restart_cmd = wr_per_i | wr_lim_load_i | wr_cnt_i;
    start_ok    = (run_per_i | run_one_i) && !running && (pint_q_i != '0);
    restart_o   = start_ok || (running && restart_cmd);
    mode_d      = mode_q;
    cnt_d       = cnt_q;
    irq_d       = 1'b0;
    rl          = '0;
    if (start_ok) begin
      mode_d = run_one_i ? MODE_ONESHOT : MODE_PERIODIC;
      rl     = reload_f(cnt_q, lim_nx_i);
      irq_d  = rl[CNT_W];
      cnt_d  = rl[CNT_W-1:0];
      if (rl[CNT_W+1]) mode_d = MODE_OFF;
    end else if (halt_i) begin
      mode_d = MODE_OFF;
    end else if (wr_cnt_i || wr_lim_load_i) begin
      cnt_d = data_i;
      if (running) begin
        rl    = reload_f(data_i, lim_nx_i);
        irq_d = rl[CNT_W];
        cnt_d = rl[CNT_W-1:0];
        if (rl[CNT_W+1]) mode_d = MODE_OFF;
      end
    end else if (wr_per_i && running) begin
      if (pint_nx_i == '0) mode_d = MODE_OFF;
    end else if (tick_i && running) begin
      if (cnt_q == CNT_W'(1)) begin
        irq_d = 1'b1;
        if (mode_q == MODE_ONESHOT) begin
          mode_d = MODE_OFF;
          cnt_d  = '0;
        end else begin
          cnt_d = lim_nx_i;
          if (lim_nx_i == '0) mode_d = MODE_OFF;
        end
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
    cnt_en = (cnt_d != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      cnt_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      irq_q  <= irq_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign mode_o  = mode_q;
  assign count_o = cnt_q;
  assign irq_o   = irq_q;
  assign run_o   = running;

endmodule

// File: rtl/cdt_timer.sv
// Top level: reset synchronizer, command decode, configuration, tick and control.
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PER_W  = 16,
  parameter int FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [CNT_W-1:0]  cmd_data_i,
  input  logic [FRAC_W-1:0] cmd_frac_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [1:0]        mode_o,
  output logic              irq_o
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cdt_op_e op;
  logic    wr_per_int, wr_per_frac, wr_lim, wr_lim_load, wr_cnt;
  logic    run_per, run_one, halt;

  always_comb begin
    op          = cdt_op_e'(cmd_op_i);
    wr_per_int  = cmd_valid_i && (op == OP_PER_INT);
    wr_per_frac = cmd_valid_i && (op == OP_PER_FRAC);
    wr_lim      = cmd_valid_i && (op == OP_LIM || op == OP_LIM_LOAD);
    wr_lim_load = cmd_valid_i && (op == OP_LIM_LOAD);
    wr_cnt      = cmd_valid_i && (op == OP_CNT);
    run_per     = cmd_valid_i && (op == OP_RUN_PER);
    run_one     = cmd_valid_i && (op == OP_RUN_ONE);
    halt        = cmd_valid_i && (op == OP_HALT);
  end

  logic [CNT_W-1:0]  lim_nx;
  logic [PER_W-1:0]  pint_q, pint_nx;
  logic [FRAC_W-1:0] frac_q;
  logic              tick, run, restart;
  cdt_mode_e         mode;

  cdt_cfg #(.CNT_W(CNT_W), .PER_W(PER_W), .FRAC_W(FRAC_W)) u_cfg (
    .clk(clk), .rst_n(rst_int_n),
    .wr_per_int_i(wr_per_int), .wr_per_frac_i(wr_per_frac), .wr_lim_i(wr_lim),
    .data_i(cmd_data_i), .frac_i(cmd_frac_i),
    .lim_nx_o(lim_nx), .pint_q_o(pint_q), .pint_nx_o(pint_nx), .frac_q_o(frac_q)
  );

  cdt_tick_gen #(.PER_W(PER_W), .FRAC_W(FRAC_W)) u_tick (
    .clk(clk), .rst_n(rst_int_n), .run_i(run), .restart_i(restart),
    .pint_i(pint_q), .frac_i(frac_q), .tick_o(tick)
  );

  cdt_ctrl #(.CNT_W(CNT_W), .PER_W(PER_W)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n),
    .wr_per_i(wr_per_int | wr_per_frac), .wr_lim_load_i(wr_lim_load),
    .wr_cnt_i(wr_cnt), .run_per_i(run_per), .run_one_i(run_one), .halt_i(halt),
    .data_i(cmd_data_i), .lim_nx_i(lim_nx), .pint_q_i(pint_q), .pint_nx_i(pint_nx),
    .tick_i(tick), .mode_o(mode), .count_o(count_o), .irq_o(irq_o),
    .run_o(run), .restart_o(restart)
  );

  assign mode_o = mode;

endmodule

// File: rtl/cdt_timer_chk.sv
// Port-level properties of the countdown timer.
module cdt_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid_i,
  input logic [CNT_W-1:0] count_o,
  input logic [1:0]       mode_o,
  input logic             irq_o
);

  p_mode_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'd3);

  p_run_nonzero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'd0) |-> (count_o != '0));

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'd0 && !cmd_valid_i) |=>
      (irq_o || count_o == $past(count_o) || count_o == $past(count_o) - CNT_W'(1)));

  p_oneshot_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2 && !cmd_valid_i) |=>
      (mode_o == 2'd2 || (mode_o == 2'd0 && count_o == '0 && irq_o)));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0 && !cmd_valid_i) |=> ($stable(count_o) && mode_o == 2'd0 && !irq_o));

  p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(cmd_valid_i) || $past(mode_o) != 2'd0));

endmodule

bind cdt_timer cdt_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i),
  .count_o(count_o), .mode_o(mode_o), .irq_o(irq_o)
);

// File: tb/cdt_timer_tb_top.sv
module cdt_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam longint MASK32 = 64'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid_i;
  logic [2:0]  cmd_op_i;
  logic [31:0] cmd_data_i;
  logic [31:0] cmd_frac_i;
  logic [31:0] count_o;
  logic [1:0]  mode_o;
  logic        irq_o;

  int tests_run = 0;
  int tests_failed = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cdt_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .cmd_data_i(cmd_data_i), .cmd_frac_i(cmd_frac_i),
    .count_o(count_o), .mode_o(mode_o), .irq_o(irq_o)
  );

  // Behavioural reference model
  int     m_mode, m_rem;
  longint m_cnt, m_lim, m_pint, m_frac, m_acc;
  bit     m_irq;

  task automatic m_reload();
    if (m_cnt == 0) begin m_irq = 1; m_cnt = m_lim; end
    if (m_cnt == 0) m_mode = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_lim = 0; m_pint = 0; m_frac = 0;
      m_acc = 0; m_rem = 0; m_irq = 0;
    end else begin
      automatic bit run = (m_mode != 0);
      automatic bit took = 0;
      automatic bit rs = 0;
      m_irq = 0;
      if (cmd_valid_i) begin
        case (cmd_op_i)
          3'd0, 3'd1: begin
            m_pint = longint'(cmd_data_i) & 64'hFFFF;
            m_frac = (cmd_op_i == 3'd1) ? longint'(cmd_frac_i) : 0;
            if (run) begin took = 1; rs = 1; if (m_pint == 0) m_mode = 0; end
          end
          3'd2: m_lim = longint'(cmd_data_i);
          3'd3, 3'd4: begin
            if (cmd_op_i == 3'd3) m_lim = longint'(cmd_data_i);
            m_cnt = longint'(cmd_data_i);
            if (run) begin took = 1; rs = 1; m_reload(); end
          end
          3'd5, 3'd6: if (!run && m_pint != 0) begin
            m_mode = (cmd_op_i == 3'd5) ? 1 : 2; rs = 1; m_reload();
          end
          default: begin took = 1; m_mode = 0; end
        endcase
      end
      if (run && !took) begin
        m_rem = m_rem - 1;
        if (m_rem == 0) begin
          m_acc = m_acc + m_frac;
          m_rem = int'(m_pint + (m_acc >> 32));
          m_acc = m_acc & MASK32;
          if (m_cnt == 1) begin
            m_irq = 1;
            if (m_mode == 2) begin m_mode = 0; m_cnt = 0; end
            else begin m_cnt = m_lim; if (m_lim == 0) m_mode = 0; end
          end else m_cnt = m_cnt - 1;
        end
      end
      if (rs) begin m_acc = 0; m_rem = int'(m_pint); end
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    tests_run++;
    if (act != exp) begin
      tests_failed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      check("R3", "model count", longint'(count_o), m_cnt);
      check("R2", "model mode", longint'(mode_o), longint'(m_mode));
      check("R5", "model irq", longint'(irq_o), longint'(m_irq));
      if (mode_o != 2'd0) check("R13", "count while running", longint'(count_o != 0), 1);
    end
  end

  task automatic issue(input logic [2:0] op, input logic [31:0] d, input logic [31:0] f);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_data_i = d; cmd_frac_i = f;
    @(negedge clk);
    cmd_valid_i = 1'b0; cmd_op_i = 3'd0; cmd_data_i = '0; cmd_frac_i = '0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect3(input string req, input longint c, input longint m, input longint q);
    check(req, "count", longint'(count_o), c);
    check(req, "mode", longint'(mode_o), m);
    check(req, "irq", longint'(irq_o), q);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cmd_valid_i = 1'b0; cmd_op_i = '0; cmd_data_i = '0; cmd_frac_i = '0;
    step(3);
    expect3("R1", 0, 0, 0);
    rst_n = 1'b1;
    step(4);
    expect3("R1", 0, 0, 0);
    cmp_en = 1'b1;
    issue(3'd5, 0, 0);                       // R8: zero period start rejected
    expect3("R8", 0, 0, 0);
    issue(3'd0, 4, 0);
    issue(3'd3, 3, 0);                       // R9: load while stopped
    expect3("R9", 3, 0, 0);
    issue(3'd2, 5, 0);                       // R9: limit only
    expect3("R9", 3, 0, 0);
    issue(3'd6, 0, 0);                       // R2 one-shot start
    expect3("R2", 3, 2, 0);
    step(3); check("R3", "before first tick", longint'(count_o), 3);
    step(1); check("R3", "first tick", longint'(count_o), 2);
    step(8); expect3("R5", 0, 0, 1);         // one-shot expiry
    step(1); check("R5", "irq single cycle", longint'(irq_o), 0);
    issue(3'd5, 0, 0);                       // R7: zero count at start
    expect3("R7", 5, 1, 1);
    issue(3'd6, 0, 0);                       // R8: start while running ignored
    check("R8", "mode kept", longint'(mode_o), 1);
    issue(3'd4, 2, 0);                       // R10: running count write
    expect3("R10", 2, 1, 0);
    step(4); check("R10", "restart tick", longint'(count_o), 1);
    step(4); expect3("R6", 5, 1, 1);         // periodic reload
    step(2); issue(3'd7, 0, 0);              // R11 stop mid tick
    expect3("R11", 5, 0, 0);
    step(10); check("R11", "held", longint'(count_o), 5);
    issue(3'd5, 0, 0);
    step(3); check("R11", "full period", longint'(count_o), 5);
    step(1); check("R11", "after period", longint'(count_o), 4);
    step(2); issue(3'd0, 3, 0);              // R12 period write restarts
    step(2); check("R12", "restart", longint'(count_o), 4);
    step(1); check("R12", "new period", longint'(count_o), 3);
    issue(3'd0, 0, 0);                       // R12 zero period disables
    expect3("R12", 3, 0, 0);
    issue(3'd1, 2, 32'h8000_0000);           // R4 fractional period
    issue(3'd4, 10, 0);
    issue(3'd5, 0, 0);
    step(6); check("R4", "ticks at 2,4", longint'(count_o), 8);
    step(1); check("R4", "tick at 7", longint'(count_o), 7);
    step(5); check("R4", "ticks 9,12", longint'(count_o), 5);
    issue(3'd0, 2, 0);                       // R12 integer form clears fraction
    step(6); check("R12", "fraction cleared", longint'(count_o), 2);
    issue(3'd3, 7, 0);                       // R9 load while running
    check("R9", "loaded", longint'(count_o), 7);
    step(1); check("R9", "restarted", longint'(count_o), 7);
    step(1); check("R9", "tick", longint'(count_o), 6);
    issue(3'd4, 0, 0);                       // R7 zero count while running
    expect3("R7", 7, 1, 1);
    issue(3'd2, 0, 0);
    issue(3'd4, 1, 0);
    step(2); expect3("R6", 0, 0, 1);         // zero limit at periodic expiry
    issue(3'd4, 9, 0);                       // R10 stopped write
    expect3("R10", 9, 0, 0);
    step(5); check("R10", "no countdown", longint'(count_o), 9);
    issue(3'd4, 0, 0);
    issue(3'd0, 2, 0);
    issue(3'd6, 0, 0);                       // R7 zero count, zero limit
    expect3("R7", 0, 0, 1);
    step(5);
    finish_run();
  end

endmodule